// File: doc/BRIEF.md
# Multichannel ADC Serial Frame Host

This block is the host side of a framed four-wire serial link to a 12-bit multichannel successive-approximation converter. When user logic asks for a transfer, the block lowers chip select and waits a setup interval. It then produces sixteen serial clock periods. During these it shifts a 16-bit control word out, most significant bit first, and collects a 16-bit result word. At the end it raises chip select and splits the result into a 3-bit channel tag, a sign bit and a 12-bit magnitude.

The converter needs a longer setup from chip select to the first clock edge when its unipolar range is in use. The host picks the longer interval whenever `unipolar_i` is high at launch. All timing limits are given as nanosecond parameters. They are turned into system-clock counts by rounding up. After each frame a single gap counter holds chip select high for the longer of the quiet time and the minimum chip-select high time. A request that arrives during a frame or during the gap is remembered and served as soon as the gap ends.

Top module: `adc_frame_host`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `adc_cs_n_o` and `adc_sclk_o` are 1, and `done_o` and `busy_o` are 0.
- R2: `adc_cs_n_o` stays low for the whole frame, and exactly 16 falling edges of `adc_sclk_o` occur in it. Chip select rises in the same cycle as the rising clock edge that ends the 16th low phase. `adc_sclk_o` is 1 whenever `adc_cs_n_o` is 1.
- R3: Each low phase of `adc_sclk_o` lasts LO = floor(D/2) system cycles and each high phase lasts D - LO cycles, where D = max(4, `SCLK_DIV`).
- R4: From the chip-select fall to the first clock fall there are SB cycles if `unipolar_i` was 0 in the launch cycle, and SU cycles if it was 1. Here SB = max(2, ceil(`SETUP_BIP_NS`·1000/`SYS_CLK_PS`)) and SU = max(SB, ceil(`SETUP_UNI_NS`·1000/`SYS_CLK_PS`)).
- R5: `ctrl_word_i` is latched in the launch cycle. Bit 15 appears on `adc_mosi_o` when chip select falls, and bit 15-k is present at the (k+1)-th clock fall. The data line changes only on rising clock edges, and later changes of `ctrl_word_i` do not alter the frame in progress.
- R6: `adc_miso_i` is sampled one system cycle before each clock fall, and the 16 samples form a word with the first sample as bit 15. `chan_o` is word bits 15:13, `sign_o` is bit 12 and `mag_o` is bits 11:0.
- R7: `done_o` is high for exactly one cycle, the cycle in which chip select rises. `chan_o`, `sign_o` and `mag_o` change only at that moment and hold until the next `done_o`.
- R8: Chip select stays high for at least GAP cycles between frames and after reset, where GAP = max(1, ceil(`QUIET_NS`·1000/`SYS_CLK_PS`), ceil(`CS_HIGH_NS`·1000/`SYS_CLK_PS`)). When a request is waiting, the next fall comes exactly GAP cycles after the rise.
- R9: A `start_i` pulse seen during a frame or a gap is held and served once. Any number of pulses in that window yield a single frame. `busy_o` is 1 from the cycle after an accepted request until its frame ends with nothing left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame |
| unipolar_i | input | 1 | Selects the longer setup interval |
| ctrl_word_i | input | 16 | Control word to send, bit 15 first |
| busy_o | output | 1 | Request accepted and not yet finished |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| chan_o | output | 3 | Channel tag of the last result |
| sign_o | output | 1 | Sign bit of the last result |
| mag_o | output | 12 | Magnitude of the last result |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| adc_mosi_o | output | 1 | Serial data to the converter |
| adc_miso_i | input | 1 | Serial data from the converter |

## Verification
A wrong phase or setup count shows up as soon as the first affected clock edge: a setup, low or high interval at the pins that differs from its computed cycle count. A bit counter off by one moves the chip-select rise against the last clock fall. It also shifts every field of the result, and that is visible at the `done_o` pulse of the same frame. A lost or duplicated pending request shows up in the gap that follows: a frame that never starts, or an extra chip-select fall. A wrong gap count shows up in the measured high time of chip select at the next launch.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CHAN_W     = 3;
  localparam int MAG_W      = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH
  } frame_state_e;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              sign;
    logic [MAG_W-1:0]  mag;
  } adc_word_t;

  // Round a nanosecond minimum up to whole system-clock cycles.
  function automatic int ns_to_cycles(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_interval_timer.sv
`timescale 1ns/1ps
module adc_interval_timer #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         expired_o
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= W'(RST_VAL);
    end else if (load_i) begin
      count_q <= load_val_i;
    end else if (count_q != '0) begin
      count_q <= count_q - W'(1);
    end
  end

  assign count_o   = count_q;
  assign expired_o = (count_q == '0);

  // R3
  tick_down_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> count_q <= $past(count_q));

endmodule

// File: rtl/adc_word_shifter.sv
`timescale 1ns/1ps
module adc_word_shifter
  import adc_host_pkg::*;
#(
  parameter int BITS = FRAME_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [BITS-1:0] word_i,
  input  logic            advance_i,
  input  logic            capture_i,
  input  logic            miso_i,
  input  logic            commit_i,
  output logic            mosi_o,
  output adc_word_t       result_o
);

  logic [BITS-1:0] tx_q;
  logic [BITS-1:0] rx_q;
  logic            mosi_q;
  adc_word_t       result_q;

  // Outgoing side: the first bit goes to the pin at launch, the rest follow.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      mosi_q <= word_i[BITS-1];
      tx_q   <= {word_i[BITS-2:0], 1'b0};
    end else if (advance_i) begin
      mosi_q <= tx_q[BITS-1];
      tx_q   <= {tx_q[BITS-2:0], 1'b0};
    end
  end

  // Incoming side: the first sample ends up as the word's top bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (capture_i) begin
      rx_q <= {rx_q[BITS-2:0], miso_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (commit_i) begin
      result_q <= rx_q;
    end
  end

  assign mosi_o   = mosi_q;
  assign result_o = result_q;

  // R6
  cap_commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(capture_i && commit_i));

  // R5
  load_adv_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_i && advance_i));

endmodule

// File: rtl/adc_frame_host.sv
`timescale 1ns/1ps
module adc_frame_host
  import adc_host_pkg::*;
#(
  parameter int SYS_CLK_PS   = 10000,
  parameter int SCLK_DIV     = 8,
  parameter int QUIET_NS     = 60,
  parameter int CS_HIGH_NS   = 15,
  parameter int SETUP_BIP_NS = 20,
  parameter int SETUP_UNI_NS = 35
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  unipolar_i,
  input  logic [FRAME_BITS-1:0] ctrl_word_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [CHAN_W-1:0]     chan_o,
  output logic                  sign_o,
  output logic [MAG_W-1:0]      mag_o,
  output logic                  adc_cs_n_o,
  output logic                  adc_sclk_o,
  output logic                  adc_mosi_o,
  input  logic                  adc_miso_i
);

  // Timing counts derived from the nanosecond minima.
  localparam int DIV_CYC  = max_of(4, SCLK_DIV);
  localparam int LO_CYC   = DIV_CYC / 2;
  localparam int HI_CYC   = DIV_CYC - LO_CYC;
  localparam int SB_CYC   = max_of(2, ns_to_cycles(SETUP_BIP_NS, SYS_CLK_PS));
  localparam int SU_CYC   = max_of(SB_CYC, ns_to_cycles(SETUP_UNI_NS, SYS_CLK_PS));
  localparam int GAP_CYC  = max_of(1, max_of(ns_to_cycles(QUIET_NS, SYS_CLK_PS),
                                             ns_to_cycles(CS_HIGH_NS, SYS_CLK_PS)));
  localparam int MAX_CYC  = max_of(max_of(GAP_CYC, SU_CYC), DIV_CYC);
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam int BCW      = $clog2(FRAME_BITS + 1);

  localparam logic [CW-1:0] LO_M1  = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] HI_M1  = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] SB_M1  = CW'(SB_CYC - 1);
  localparam logic [CW-1:0] SU_M1  = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP_CYC - 1);

  frame_state_e   state_q;
  logic [BCW-1:0] bit_q;
  logic           cs_n_q;
  logic           sclk_q;
  logic           done_q;
  logic           pend_q;

  logic           launch;
  logic           last_bit;
  logic           ph_load;
  logic [CW-1:0]  ph_val;
  logic [CW-1:0]  ph_cnt;
  logic           ph_exp;
  logic           gap_load;
  logic [CW-1:0]  gap_cnt;
  logic           gap_exp;
  logic           capture;
  logic           advance;
  logic           commit;
  logic           mosi;
  adc_word_t      result;

  // Phase timer: setup interval, then alternating low and high phases.
  adc_interval_timer #(.W(CW), .RST_VAL(0)) i_phase_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ph_load),
    .load_val_i (ph_val),
    .count_o    (ph_cnt),
    .expired_o  (ph_exp)
  );

  // Gap timer: one count covers both the quiet time and the CS high width.
  adc_interval_timer #(.W(CW), .RST_VAL(GAP_CYC)) i_gap_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (gap_load),
    .load_val_i (GAP_M1),
    .count_o    (gap_cnt),
    .expired_o  (gap_exp)
  );

  adc_word_shifter #(.BITS(FRAME_BITS)) i_shifter (
    .clk       (clk),
    .rst       (rst),
    .load_i    (launch),
    .word_i    (ctrl_word_i),
    .advance_i (advance),
    .capture_i (capture),
    .miso_i    (adc_miso_i),
    .commit_i  (commit),
    .mosi_o    (mosi),
    .result_o  (result)
  );

  assign launch   = (state_q == ST_IDLE) && (start_i || pend_q) && gap_exp;
  assign last_bit = (bit_q == BCW'(FRAME_BITS));

  always_comb begin
    ph_load  = 1'b0;
    ph_val   = '0;
    gap_load = 1'b0;
    capture  = 1'b0;
    advance  = 1'b0;
    commit   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          ph_load = 1'b1;
          ph_val  = unipolar_i ? SU_M1 : SB_M1;
        end
      end
      ST_SETUP, ST_HIGH: begin
        // Sample one system cycle ahead of the coming falling edge.
        capture = (ph_cnt == CW'(1));
        if (ph_exp) begin
          ph_load = 1'b1;
          ph_val  = LO_M1;
        end
      end
      ST_LOW: begin
        if (ph_exp) begin
          if (last_bit) begin
            gap_load = 1'b1;
            commit   = 1'b1;
          end else begin
            ph_load = 1'b1;
            ph_val  = HI_M1;
            advance = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        pend_q <= 1'b0;
      end else if (start_i) begin
        pend_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            cs_n_q  <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP, ST_HIGH: begin
          if (ph_exp) begin
            sclk_q  <= 1'b0;
            bit_q   <= bit_q + BCW'(1);
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (ph_exp) begin
            sclk_q <= 1'b1;
            if (last_bit) begin
              cs_n_q  <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_HIGH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE) || pend_q;
  assign done_o     = done_q;
  assign chan_o     = result.chan;
  assign sign_o     = result.sign;
  assign mag_o      = result.mag;
  assign adc_cs_n_o = cs_n_q;
  assign adc_sclk_o = sclk_q;
  assign adc_mosi_o = mosi;

  // Checker state observed at the pins.
  logic [CW:0]    hi_run_q;
  logic [BCW-1:0] fall_cnt_q;
  logic           sclk_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run_q   <= '0;
      fall_cnt_q <= '0;
      sclk_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= adc_sclk_o;
      if (!adc_cs_n_o) begin
        hi_run_q <= '0;
      end else if (hi_run_q != '1) begin
        hi_run_q <= hi_run_q + (CW+1)'(1);
      end
      if (adc_cs_n_o) begin
        fall_cnt_q <= '0;
      end else if (sclk_d_q && !adc_sclk_o) begin
        fall_cnt_q <= fall_cnt_q + BCW'(1);
      end
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n_o |-> adc_sclk_o);

  // R2
  frame_falls_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n_o) |-> fall_cnt_q == BCW'(FRAME_BITS));

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk_o) |-> $stable(adc_mosi_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(adc_cs_n_o));

  // R8
  gap_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n_o) |-> hi_run_q >= (CW+1)'(GAP_CYC));

  // R8
  gap_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n_o) |-> $past(gap_cnt) == '0);

endmodule

// File: tb/test_adc_frame_host.sv
`timescale 1ns/1ps
module test_adc_frame_host;

  localparam int PS  = 10000;
  localparam int DIV = 8;
  localparam int LO  = DIV / 2;
  localparam int HI  = DIV - LO;
  localparam int C_BIP = (20 * 1000 + PS - 1) / PS;
  localparam int C_UNI = (35 * 1000 + PS - 1) / PS;
  localparam int C_QT  = (60 * 1000 + PS - 1) / PS;
  localparam int C_CSH = (15 * 1000 + PS - 1) / PS;
  localparam int SB  = (C_BIP > 2) ? C_BIP : 2;
  localparam int SU  = (C_UNI > SB) ? C_UNI : SB;
  localparam int GAP = (C_QT > C_CSH) ? C_QT : C_CSH;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        uni = 1'b0;
  logic [15:0] ctrl = '0;
  logic        miso = 1'b0;
  logic        busy, done, sign, cs_n, sclk, mosi;
  logic [2:0]  chan;
  logic [11:0] mag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  time last_rise = 0;
  time last_fall = 0;

  always #5 clk = ~clk;

  adc_frame_host #(
    .SYS_CLK_PS(PS), .SCLK_DIV(DIV), .QUIET_NS(60), .CS_HIGH_NS(15),
    .SETUP_BIP_NS(20), .SETUP_UNI_NS(35)
  ) i_adc_frame_host (
    .clk(clk), .rst(rst), .start_i(start), .unipolar_i(uni), .ctrl_word_i(ctrl),
    .busy_o(busy), .done_o(done), .chan_o(chan), .sign_o(sign), .mag_o(mag),
    .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .adc_mosi_o(mosi), .adc_miso_i(miso)
  );

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input longint act, input longint lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Converter model plus pin timing checks for one frame.
  task automatic serve_frame(input logic [15:0] reply, input logic [15:0] exp_ctrl,
                             input bit unip, input int exp_gap);
    time tf, tp, tr;
    logic [15:0] got;
    tp = 0;
    tr = 0;
    got = '0;
    @(negedge cs_n);
    tf = $time;
    last_fall = tf;
    if (exp_gap >= 0) chk_eq("R8 gap with pending request", (tf - last_rise) / 10, exp_gap);
    #2 miso = reply[15];
    for (int k = 0; k < 16; k++) begin
      @(negedge sclk);
      tp = $time;
      if (k == 0) chk_eq(unip ? "R4 unipolar setup" : "R4 bipolar setup", (tp - tf) / 10, unip ? SU : SB);
      else        chk_eq("R3 high phase", (tp - tr) / 10, HI);
      #1;
      got[15-k] = mosi;
      chk_eq("R2 cs low in frame", cs_n, 0);
      if (k < 15) begin
        miso = reply[14-k];
        @(posedge sclk);
        tr = $time;
        chk_eq("R3 low phase", (tr - tp) / 10, LO);
      end
    end
    @(posedge cs_n);
    tr = $time;
    last_rise = tr;
    chk_eq("R2 cs rise after last low phase", (tr - tp) / 10, LO);
    #1;
    chk_eq("R2 sclk high with cs", sclk, 1);
    chk_eq("R7 done at cs rise", done, 1);
    chk_eq("R5 mosi word", got, exp_ctrl);
    chk_eq("R6 channel field", chan, reply[15:13]);
    chk_eq("R6 sign field", sign, reply[12]);
    chk_eq("R6 magnitude field", mag, reply[11:0]);
    @(posedge clk);
    #1 chk_eq("R7 done one cycle", done, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk);
    #1;
    chk_eq("R1 cs in reset", cs_n, 1);
    chk_eq("R1 sclk in reset", sclk, 1);
    chk_eq("R1 done in reset", done, 0);
    chk_eq("R1 busy in reset", busy, 0);
  endtask

  task automatic test_first_frame();
    time trel;
    ctrl = 16'hA5C3;
    @(negedge clk) rst = 1'b0;
    trel = $time;
    start = 1'b1;
    @(posedge clk);
    #1;
    chk_eq("R1 cs after release", cs_n, 1);
    chk_eq("R9 busy after request", busy, 1);
    @(negedge clk) start = 1'b0;
    serve_frame(16'h6ABC, 16'hA5C3, 1'b0, -1);
    chk_ge("R8 gap after reset", (last_fall - trel) / 10, GAP);
    chk_eq("R9 busy after frame", busy, 0);
  endtask

  task automatic test_patterns();
    ctrl = 16'h8123;
    fork
      serve_frame(16'h1F0F, 16'h8123, 1'b0, -1);
      pulse_start();
    join
    uni = 1'b1;
    ctrl = 16'h0000;
    fork
      serve_frame(16'hFFFF, 16'h0000, 1'b1, -1);
      pulse_start();
    join
    uni = 1'b0;
    ctrl = 16'hFFFF;
    fork
      serve_frame(16'h0000, 16'hFFFF, 1'b0, -1);
      pulse_start();
    join
  endtask

  task automatic test_back_to_back();
    ctrl = 16'hC3A5;
    fork
      serve_frame(16'hB5A1, 16'hC3A5, 1'b0, -1);
      begin
        pulse_start();
        @(negedge sclk);
        @(negedge clk) ctrl = 16'h5A3C;
        pulse_start();
        pulse_start();
        #1 chk_eq("R9 busy during frame", busy, 1);
      end
    join
    serve_frame(16'h4E72, 16'h5A3C, 1'b0, GAP);
    repeat (4 * GAP) @(posedge clk);
    #1;
    chk_eq("R9 single extra frame", cs_n, 1);
    chk_eq("R9 idle after queue", busy, 0);
    chk_eq("R7 channel held", chan, 3'h2);
    chk_eq("R7 magnitude held", mag, 12'hE72);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    test_reset();
    test_first_frame();
    test_patterns();
    test_back_to_back();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

endmodule